// File: doc/BRIEF.md
# Lean bfloat16 Multiplier

This block multiplies two bfloat16 operands and returns a bfloat16 product. Each operand has a sign bit, an 8-bit exponent with a bias of 127, and 7 stored fraction bits. A leading 1 is implied in front of the fraction. The block forms the full 8 x 8 significand product with both implied ones included. It adds the exponents and removes the bias. It then normalises by at most one place and drops the surplus low bits, which rounds toward zero.

The block is meant for dense arithmetic arrays where area matters more than full standard coverage. There is no special-value logic: callers must never supply infinities, NaNs or subnormals. The only special input it honours is an operand whose exponent field is zero, which it treats as a signed zero. Results that fall below the normal range flush to zero with the product's sign. Results above the range clamp to the largest finite magnitude, so the block never produces an infinity.

The product is registered, so it appears on the output one clock after the operands are presented. A new operand pair is accepted on every cycle.

Top module: `bf16_mul_lean`

## Requirements
- R1: Operand and result words use the layout {sign[15], exponent[14:7], fraction[6:0]} with exponent bias 127. For an in-range result, the exponent field is exp_a + exp_b - 127, plus 1 when normalisation applies, and the fraction is taken from the product of the significands {1,frac}.
- R2: The result sign bit equals the XOR of the two operand sign bits in every case, including zero, flushed and saturated results.
- R3: When the computed exponent is 255 or more, the result is {sign, 8'hFE, 7'h7F}. An exponent field of 8'hFF never appears on the output.
- R4: When the computed exponent is 0 or less, the result is {sign, 15'h0}, so no subnormal is ever produced.
- R5: An operand whose exponent field is 0 forces the result {sign, 15'h0}, whatever its fraction bits hold.
- R6: Product bits below the kept fraction are discarded with no increment (round toward zero).
- R7: When the 16-bit significand product has bit 15 set, the kept fraction is product[14:8] and the exponent gains 1. Otherwise the kept fraction is product[13:7].
- R8: The result is registered. It reflects the operands sampled at the previous rising clock edge, and it is 16'h0000 while reset is active.
- R9: The range checks use the exponent after normalisation. A biased sum of 0 that normalises becomes exponent 1, and a biased sum of 254 that normalises saturates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge samples the operands |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 16 | First bfloat16 operand |
| op_b | input | 16 | Second bfloat16 operand |
| result | output | 16 | Registered bfloat16 product |

## Verification
The one-place normalisation shift and the range clamps can act on the same product. That happens when the biased exponent sum sits exactly at a range edge and both significands are large enough to carry into bit 15. The bench builds such pairs on purpose: a sum of 0 with full fractions, which must come out as exponent 1 and not as zero, and a sum of 254 with full fractions, which must saturate. It checks each of them against the same pair with empty fractions, which must flush to zero or land exactly at exponent 254. A reference model computes each expected word from integer significand arithmetic on its own terms and compares it with the output one cycle later.

// File: rtl/bf16_mul_pkg.sv
package bf16_mul_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 7;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 2;
  localparam int ESUM_W  = EXP_W + 2;

  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } bf16_t;

  // significand product with both implied ones restored
  function automatic logic [PROD_W-1:0] sig_product(input logic [FRAC_W-1:0] fa,
                                                    input logic [FRAC_W-1:0] fb);
    logic [PROD_W-1:0] xa, xb;
    xa = PROD_W'({1'b1, fa});
    xb = PROD_W'({1'b1, fb});
    return xa * xb;
  endfunction

  // biased exponent after normalisation, signed so underflow stays visible
  function automatic logic signed [ESUM_W-1:0] exp_total(input logic [EXP_W-1:0] ea,
                                                         input logic [EXP_W-1:0] eb,
                                                         input logic norm);
    logic signed [ESUM_W-1:0] s;
    s = $signed(ESUM_W'(ea)) + $signed(ESUM_W'(eb)) - $signed(ESUM_W'(BIAS))
        + $signed(ESUM_W'(norm));
    return s;
  endfunction
endpackage

// File: rtl/bf16_field_split.sv
module bf16_field_split
  import bf16_mul_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output bf16_t             fields,
  output logic              is_zero
);
  always_comb begin
    fields  = bf16_t'(word);
    is_zero = (fields.exp == '0);
  end
endmodule

// File: rtl/bf16_sig_core.sv
module bf16_sig_core
  import bf16_mul_pkg::*;
(
  input  logic [FRAC_W-1:0] frac_a,
  input  logic [FRAC_W-1:0] frac_b,
  output logic [FRAC_W-1:0] frac_out,
  output logic              norm,
  output logic              trunc
);
  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = sig_product(frac_a, frac_b);
    norm = prod[PROD_W-1];
    if (norm) begin
      frac_out = prod[PROD_W-2 -: FRAC_W];
      trunc    = |prod[SIG_W-1:0];
    end else begin
      frac_out = prod[PROD_W-3 -: FRAC_W];
      trunc    = |prod[SIG_W-2:0];
    end
  end
endmodule

// File: rtl/bf16_range_pack.sv
module bf16_range_pack
  import bf16_mul_pkg::*;
(
  input  logic              sgn,
  input  logic [EXP_W-1:0]  exp_a,
  input  logic [EXP_W-1:0]  exp_b,
  input  logic              norm,
  input  logic [FRAC_W-1:0] frac,
  input  logic              zero_in,
  output logic [WORD_W-1:0] word,
  output logic              ovf,
  output logic              unf
);
  logic signed [ESUM_W-1:0] etot;
  bf16_t                    res;

  always_comb begin
    etot = exp_total(exp_a, exp_b, norm);
    ovf  = (etot > EXP_MAX);
    unf  = (etot < 1);
    res.sgn = sgn;
    if (zero_in || unf) begin
      res.exp  = '0;
      res.frac = '0;
    end else if (ovf) begin
      res.exp  = EXP_W'(EXP_MAX);
      res.frac = '1;
    end else begin
      res.exp  = etot[EXP_W-1:0];
      res.frac = frac;
    end
    word = res;
  end
endmodule

// File: rtl/bf16_mul_lean.sv
module bf16_mul_lean
  import bf16_mul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] result
);
  localparam int N_OPS = 2;

  logic [WORD_W-1:0] ops   [N_OPS];
  bf16_t             flds  [N_OPS];
  logic              zflag [N_OPS];

  // named internal events for the checker
  logic              zero_evt, ovf_evt, unf_evt, norm_evt, trunc_evt;
  logic [FRAC_W-1:0] frac_kept;
  logic [WORD_W-1:0] word_next;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  generate
    for (genvar i = 0; i < N_OPS; i++) begin : g_split
      bf16_field_split u_split (
        .word    (ops[i]),
        .fields  (flds[i]),
        .is_zero (zflag[i])
      );
    end
  endgenerate

  assign zero_evt = zflag[0] | zflag[1];

  bf16_sig_core u_sig (
    .frac_a   (flds[0].frac),
    .frac_b   (flds[1].frac),
    .frac_out (frac_kept),
    .norm     (norm_evt),
    .trunc    (trunc_evt)
  );

  bf16_range_pack u_pack (
    .sgn     (flds[0].sgn ^ flds[1].sgn),
    .exp_a   (flds[0].exp),
    .exp_b   (flds[1].exp),
    .norm    (norm_evt),
    .frac    (frac_kept),
    .zero_in (zero_evt),
    .word    (word_next),
    .ovf     (ovf_evt),
    .unf     (unf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) result <= '0;
    else        result <= word_next;
  end
endmodule

module bf16_mul_lean_chk
  import bf16_mul_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic [WORD_W-1:0] result,
  input logic              zero_evt,
  input logic              ovf_evt,
  input logic              unf_evt,
  input logic              norm_evt,
  input logic              trunc_evt
);
  localparam int EB = WORD_W - 2;
  localparam int FT = FRAC_W - 1;

  p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1]));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result[EB -: EXP_W] != '1);

  p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !zero_evt) |=> result[EB:0] == {EXP_W'(EXP_MAX), {FRAC_W{1'b1}}});

  p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_evt && !zero_evt) |=> result[EB:0] == '0);

  p_zero_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> result[EB:0] == '0);

  p_exact_no_trunc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a[FT:0] == '0 && op_b[FT:0] == '0) |-> !trunc_evt && !norm_evt);

  p_range_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_evt, unf_evt}));

  p_norm_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_evt && !ovf_evt && !unf_evt) |=>
      result[EB -: EXP_W] == EXP_W'($past(op_a[EB -: EXP_W]) + $past(op_b[EB -: EXP_W])
                                    - BIAS + $past(norm_evt)));
endmodule

bind bf16_mul_lean bf16_mul_lean_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_a      (op_a),
  .op_b      (op_b),
  .result    (result),
  .zero_evt  (zero_evt),
  .ovf_evt   (ovf_evt),
  .unf_evt   (unf_evt),
  .norm_evt  (norm_evt),
  .trunc_evt (trunc_evt)
);

// File: tb/sim_bf16_mul_lean.sv
`timescale 1ns/1ps
module sim_bf16_mul_lean;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [15:0] result;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {logic [15:0] exp_word; string req;} item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  bf16_mul_lean u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .result(result));

  // independent reference: integer significands, explicit range handling
  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b);
    int ea, eb, e, m;
    logic s;
    s  = a[15] ^ b[15];
    ea = a[14:7];
    eb = b[14:7];
    if (ea == 0 || eb == 0) return {s, 15'h0};
    m = (128 + a[6:0]) * (128 + b[6:0]);
    e = ea + eb - 127;
    if (m >= 32768) begin m = m / 256; e = e + 1; end
    else m = m / 128;
    if (e <= 0)   return {s, 15'h0};
    if (e >= 255) return {s, 8'd254, 7'h7F};
    return {s, e[7:0], m[6:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input string req);
    item_t it;
    @(negedge clk);
    op_a = a;
    op_b = b;
    it.exp_word = model(a, b);
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: each rising edge registers the pair driven at the prior falling edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.req, result, it.exp_word);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset value", result, 16'h0000);
    rst_n = 1'b1;
    // fixed expectations written from the requirements
    drive(16'h3F80, 16'h3F80, "R1 one times one");
    drive(16'h3FC0, 16'h3FC0, "R7 normalise 1.5*1.5");
    drive(16'hC000, 16'h4040, "R2 negative product");
    drive(16'h3F81, 16'h3F81, "R6 truncation");
    drive(16'h7F00, 16'h7F00, "R3 positive saturate");
    drive(16'hFF00, 16'h7F00, "R3 negative saturate");
    drive(16'h0080, 16'h0080, "R4 flush positive");
    drive(16'h8080, 16'h0080, "R4 flush negative");
    drive(16'h007F, 16'h4000, "R5 zero exponent operand");
    drive(16'h8000, 16'h3F80, "R5 negative zero");
    drive(16'h1FFF, 16'h207F, "R9 normalise rescues exponent 1");
    drive(16'h1F80, 16'h2000, "R9 no normalise flushes");
    drive(16'h3FFF, 16'h7F7F, "R9 normalise saturates");
    drive(16'h3F80, 16'h7F7F, "R9 exact at largest");
    @(posedge clk); #1;
    checks++;
    if (result !== 16'h7F7F) begin
      errors++;
      $display("FAIL R9: actual %h expected %h", result, 16'h7F7F);
    end
    // hand-computed spot checks of the model itself
    checks++;
    if (model(16'h3FC0, 16'h3FC0) !== 16'h4010 || model(16'h3F81, 16'h3F81) !== 16'h3F82 ||
        model(16'h1FFF, 16'h207F) !== 16'h00FE || model(16'hC000, 16'h4040) !== 16'hC0C0) begin
      errors++;
      $display("FAIL R1 model: actual %h expected %h", model(16'h3FC0, 16'h3FC0), 16'h4010);
    end
    // random normal operands, with occasional zero exponents
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if (a[14:7] == 8'hFF) a[14:7] = 8'hFE;
      if (b[14:7] == 8'hFF) b[14:7] = 8'hFE;
      if (($urandom % 16) == 0) a[14:7] = 8'h00;
      drive(a, b, "R1 random");
    end
    @(negedge clk);
    @(negedge clk);
    // reset mid-stream returns the output to zero
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R8 reset clears", result, 16'h0000);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule